// File: doc/BRIEF.md
# Watchdog Timer with Reset Arbitration

This block is a byte-programmable watchdog. Software turns it on by setting two bits in a control register. From then on an 8-bit counter advances once for every prescaler strobe, and software must rewrite the counter, usually with zero, before it wraps. If the counter wraps, the block asserts an internal reset for a fixed number of cycles. It also records in a status register that the watchdog caused that reset. If an output-enable status bit is set, it drives a shared active-low reset pad low for the same length of time so that external devices are reset as well.

The same pad can be pulled low from outside. The block synchronizes the pad level and turns an external low into an internal reset. It also decides which source wins when the pad goes low in the same cycle as an overflow. With output-enable set, the watchdog wins. The pad is then checked once more at the end of a longer window that starts at the overflow, and a pad still held low from outside at that point starts an external reset. With output-enable clear, the external reset wins at once.

Top module: `wdt_reset_arbiter`

## Requirements
- R1: The counter advances by one per `tick` strobe only while both the mode bit (bit 6) and the enable bit (bit 5) of the control register (address 0) are 1; with either bit at 0 the count holds.
- R2: A write to address 1 loads the counter and takes priority over a strobe in the same cycle. A strobe while running at 0xFF wraps the count to 0x00 and starts a watchdog reset.
- R3: A watchdog reset asserts `sys_rst_o` for exactly 132 cycles. `pad_drive_o` is asserted in those same 132 cycles when the output-enable bit (status bit 6, address 2) was 1 at the overflow, and is never asserted when that bit was 0.
- R4: A watchdog reset sets the watchdog-source flag (status bit 7), and that reset leaves the flag at 1. Writing 0 to bit 7 clears the flag, writing 1 to it leaves the flag unchanged, and bit 6 takes the written value.
- R5: A pad low from outside while idle, seen after a two-stage synchronizer, holds `sys_rst_o` high until the pad returns high and clears both status bits.
- R6: If the synchronized external low coincides with an overflow while output-enable is 1, the watchdog reset wins (R3 pulse, flag set). If the pad is still low 520 cycles after the overflow, an external reset starts then and clears both status bits.
- R7: If the synchronized external low coincides with an overflow while output-enable is 0, the external reset wins: `sys_rst_o` rises, the pad is not driven and the flag is cleared.
- R8: Any reset, whether from the watchdog, from the pad or from power-on, returns the mode bit, the enable bit and the counter to 0. Register writes are ignored while `sys_rst_o` is high.
- R9: A read returns `{0, mode, enable, 00000}` at address 0, the count at address 1, `{flag, oe, 000000}` at address 2 and 0x00 at address 3.
- R10: The block's own pad drive is never taken for an external reset. After a watchdog pulse with the pad otherwise high, `sys_rst_o` stays low at the window's end and the flag and output-enable bits both remain 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Prescaler strobe qualifying each count |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| pad_in | input | 1 | Level observed on the reset pad |
| pad_drive_o | output | 1 | Open-drain pull-down enable for the pad |
| sys_rst_o | output | 1 | Internal reset, active high |

## Verification
The hardest situation to reach from the ports is an external pad low that the arbiter sees in the very cycle the counter wraps. The synchronizer delays the pad by two edges, so the bench loads 0xFF with no strobe, pulls the pad low, waits exactly two rising edges and only then raises `tick` for one edge. Both events therefore land on the same decision edge. From that edge the bench counts cycles. It checks the pulse length, that reset stays low at cycle 519 and high at 520 while the pad is held, and the outcome when the pad is released early.

// File: rtl/wdt_arb_pkg.sv
package wdt_arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_PULSE = 2'd1,
      ARB_HOLD  = 2'd2,
      ARB_EXT   = 2'd3
   } arb_state_e;

   localparam logic [1:0] REG_CTRL  = 2'd0;
   localparam logic [1:0] REG_COUNT = 2'd1;
   localparam logic [1:0] REG_STAT  = 2'd2;

   localparam int CTRL_MODE_BIT = 6;
   localparam int CTRL_EN_BIT   = 5;
   localparam int STAT_FLAG_BIT = 7;
   localparam int STAT_OE_BIT   = 6;
   localparam int BYTE_W        = 8;

endpackage

// File: rtl/wdt_pad_sync.sv
module wdt_pad_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_i,
   output logic low_o
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("wdt_pad_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b1;
            else        chain_q <= pad_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pad_i};
         end
      end
   endgenerate

   assign low_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (run && tick)  cnt_q <= cnt_q + 1'b1;
   end

   assign wrap_o = run && tick && !load && !clr && (cnt_q == CNT_MAX);
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdt_arbiter.sv
module wdt_arbiter
   import wdt_arb_pkg::*;
#(
   parameter int PULSE_CYC = 132,
   parameter int WIN_CYC   = 520
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic ext_low_i,
   input  logic oe_i,
   output logic drive_o,
   output logic sys_rst_o,
   output logic take_wdog_o,
   output logic take_ext_o
);
   localparam int WIN_W = $clog2(WIN_CYC + 1);
   localparam logic [WIN_W-1:0] PULSE_LAST = WIN_W'(PULSE_CYC - 1);
   localparam logic [WIN_W-1:0] WIN_LAST   = WIN_W'(WIN_CYC - 1);

   generate
      if (PULSE_CYC < 1 || WIN_CYC <= PULSE_CYC) begin : g_bad
         $error("wdt_arbiter: need 0 < PULSE_CYC < WIN_CYC");
      end
   endgenerate

   arb_state_e       st_q, st_d;
   logic [WIN_W-1:0] win_q;
   logic             drv_en_q;

   always_comb begin
      st_d        = st_q;
      take_wdog_o = 1'b0;
      take_ext_o  = 1'b0;
      unique case (st_q)
         ARB_IDLE: begin
            if (wrap_i && (!ext_low_i || oe_i)) begin
               st_d        = ARB_PULSE;
               take_wdog_o = 1'b1;
            end else if (ext_low_i) begin
               st_d       = ARB_EXT;
               take_ext_o = 1'b1;
            end
         end
         ARB_PULSE: begin
            if (win_q == PULSE_LAST) st_d = drv_en_q ? ARB_HOLD : ARB_IDLE;
         end
         ARB_HOLD: begin
            if (win_q == WIN_LAST) begin
               if (ext_low_i) begin
                  st_d       = ARB_EXT;
                  take_ext_o = 1'b1;
               end else begin
                  st_d = ARB_IDLE;
               end
            end
         end
         ARB_EXT: begin
            take_ext_o = 1'b1;
            if (!ext_low_i) st_d = ARB_IDLE;
         end
         default: st_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ARB_IDLE;
         win_q    <= '0;
         drv_en_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ARB_PULSE || st_q == ARB_HOLD) win_q <= win_q + 1'b1;
         else                                       win_q <= '0;
         if (take_wdog_o) drv_en_q <= oe_i;
      end
   end

   assign drive_o   = (st_q == ARB_PULSE) && drv_en_q;
   assign sys_rst_o = (st_q == ARB_PULSE) || (st_q == ARB_EXT);
endmodule

// File: rtl/wdt_reset_arbiter.sv
module wdt_reset_arbiter
   import wdt_arb_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_CYC   = 132,
   parameter int WIN_CYC     = 520
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       bus_we,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       pad_in,
   output logic       pad_drive_o,
   output logic       sys_rst_o
);
   generate
      if (CNT_W < 2 || CNT_W > BYTE_W) begin : g_bad_w
         $error("wdt_reset_arbiter: CNT_W must be in 2..8");
      end
   endgenerate

   logic             mode_q, en_q, flag_q, oe_q;
   logic [CNT_W-1:0] cnt;
   logic             wrap, ext_low, take_wdog, take_ext, sys_rst;
   logic             wr_ok, wr_ctrl, wr_cnt, wr_stat;

   assign wr_ok   = bus_we && !sys_rst;
   assign wr_ctrl = wr_ok && (bus_addr == REG_CTRL);
   assign wr_cnt  = wr_ok && (bus_addr == REG_COUNT);
   assign wr_stat = wr_ok && (bus_addr == REG_STAT);

   wdt_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pad_i (pad_in),
      .low_o (ext_low)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sys_rst),
      .run      (mode_q && en_q),
      .tick     (tick),
      .load     (wr_cnt),
      .load_val (bus_wdata[CNT_W-1:0]),
      .cnt_o    (cnt),
      .wrap_o   (wrap)
   );

   wdt_arbiter #(.PULSE_CYC(PULSE_CYC), .WIN_CYC(WIN_CYC)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .wrap_i      (wrap),
      .ext_low_i   (ext_low),
      .oe_i        (oe_q),
      .drive_o     (pad_drive_o),
      .sys_rst_o   (sys_rst),
      .take_wdog_o (take_wdog),
      .take_ext_o  (take_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         en_q   <= 1'b0;
      end else if (sys_rst) begin
         mode_q <= 1'b0;
         en_q   <= 1'b0;
      end else if (wr_ctrl) begin
         mode_q <= bus_wdata[CTRL_MODE_BIT];
         en_q   <= bus_wdata[CTRL_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         oe_q   <= 1'b0;
      end else if (take_ext) begin
         flag_q <= 1'b0;
         oe_q   <= 1'b0;
      end else begin
         if (take_wdog)                              flag_q <= 1'b1;
         else if (wr_stat && !bus_wdata[STAT_FLAG_BIT]) flag_q <= 1'b0;
         if (wr_stat) oe_q <= bus_wdata[STAT_OE_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_CTRL: begin
            bus_rdata[CTRL_MODE_BIT] = mode_q;
            bus_rdata[CTRL_EN_BIT]   = en_q;
         end
         REG_COUNT: bus_rdata = BYTE_W'(cnt);
         REG_STAT: begin
            bus_rdata[STAT_FLAG_BIT] = flag_q;
            bus_rdata[STAT_OE_BIT]   = oe_q;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign sys_rst_o = sys_rst;
endmodule

// File: rtl/wdt_reset_arbiter_chk.sv
module wdt_reset_arbiter_chk #(
   parameter int PULSE_CYC = 132,
   parameter int CNT_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sys_rst,
   input logic             drive,
   input logic             oe,
   input logic             flag,
   input logic             mode,
   input logic             en,
   input logic [CNT_W-1:0] cnt
);
   logic [15:0] run_q;
   logic        drive_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         drive_d <= 1'b0;
      end else begin
         drive_d <= drive;
         if (drive) run_q <= drive_d ? run_q + 16'd1 : 16'd1;
      end
   end

   AST_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> sys_rst); // R3
   AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_d && !drive) |-> (run_q == 16'(PULSE_CYC))); // R3
   AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && !drive_d) |-> oe); // R3
   AST_FLAG_ON_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && !drive_d) |-> flag); // R4
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> (!mode && !en && cnt == '0)); // R8
endmodule

bind wdt_reset_arbiter wdt_reset_arbiter_chk #(.PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sys_rst (sys_rst_o),
   .drive   (pad_drive_o),
   .oe      (oe_q),
   .flag    (flag_q),
   .mode    (mode_q),
   .en      (en_q),
   .cnt     (cnt)
);

// File: tb/wdt_reset_arbiter_bench.sv
`timescale 1ns/1ps
module wdt_reset_arbiter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       pad_drive_o, sys_rst_o;
   logic       ext_hold = 1'b0;
   logic       pad_in;
   int         total = 0;
   int         fails = 0;

   always #2 clk = ~clk;
   assign pad_in = !(pad_drive_o || ext_hold);

   wdt_reset_arbiter u_wdt_reset_arbiter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_drive_o(pad_drive_o), .sys_rst_o(sys_rst_o)
   );

   // counter value, ticks to apply, expected count
   localparam logic [23:0] VEC [0:4] = '{
      24'h00_03_03, 24'h10_05_15, 24'hF0_0E_FE, 24'h7F_01_80, 24'h40_00_40
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; #0.5; d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // sets up count 0xFF, then makes the synced pad low meet the wrap edge
   task automatic coincide();
      wr(2'd0, 8'h60); wr(2'd1, 8'hFF);
      ext_hold = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog timeout got 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int nrst, ndrv;
      idle(3); rst_n = 1'b1; idle(2);

      // reset state
      rd(2'd0, d); chk("R8 ctrl after reset", d, 8'h00);
      rd(2'd1, d); chk("R8 count after reset", d, 8'h00);
      rd(2'd2, d); chk("R9 status after reset", d, 8'h00);
      rd(2'd3, d); chk("R9 unused address", d, 8'h00);
      chk("R3 no drive at reset", pad_drive_o, 1'b0);

      // R1: only one of the two bits set -> holds
      wr(2'd0, 8'h20); ticks(4);
      rd(2'd0, d); chk("R9 ctrl readback enable only", d, 8'h20);
      rd(2'd1, d); chk("R1 enable only holds", d, 8'h00);
      wr(2'd0, 8'h40); ticks(4);
      rd(2'd1, d); chk("R1 mode only holds", d, 8'h00);

      // vector table: R1 and R2
      wr(2'd0, 8'h60);
      rd(2'd0, d); chk("R9 ctrl readback running", d, 8'h60);
      for (int v = 0; v < 5; v++) begin
         wr(2'd1, VEC[v][23:16]);
         ticks(int'(VEC[v][15:8]));
         rd(2'd1, d); chk("R1 R2 vector count", d, VEC[v][7:0]);
      end

      // R2: load beats strobe; kick prevents firing
      wr(2'd1, 8'hFF);
      tick = 1'b1; wr(2'd1, 8'h00); tick = 1'b0;
      chk("R2 kick prevents reset", sys_rst_o, 1'b0);
      ticks(3); rd(2'd1, d); chk("R2 count after kick", d, 8'h03);

      // overflow with OE=0
      wr(2'd2, 8'h00); wr(2'd1, 8'hFF); ticks(1);
      nrst = 0; ndrv = 0;
      for (int n = 0; n < 140; n++) begin
         nrst += int'(sys_rst_o); ndrv += int'(pad_drive_o); @(negedge clk);
      end
      chk("R3 internal pulse length oe0", nrst, 132);
      chk("R3 no pad drive oe0", ndrv, 0);
      rd(2'd2, d); chk("R4 flag set oe0", d, 8'h80);
      rd(2'd0, d); chk("R8 ctrl cleared by wdog", d, 8'h00);
      rd(2'd1, d); chk("R8 count cleared by wdog", d, 8'h00);
      wr(2'd2, 8'h80); rd(2'd2, d); chk("R4 write 1 keeps flag", d, 8'h80);
      wr(2'd2, 8'h00); rd(2'd2, d); chk("R4 write 0 clears flag", d, 8'h00);

      // overflow with OE=1, pad otherwise high
      wr(2'd2, 8'h40); wr(2'd0, 8'h60); wr(2'd1, 8'hFF); ticks(1);
      nrst = 0; ndrv = 0;
      for (int n = 0; n < 526; n++) begin
         if (n < 132) nrst += int'(sys_rst_o);
         ndrv += int'(pad_drive_o);
         if (n == 132) chk("R3 reset ends after pulse", sys_rst_o, 1'b0);
         if (n == 520) chk("R10 no self-triggered ext reset", sys_rst_o, 1'b0);
         @(negedge clk);
      end
      chk("R3 pulse cycles oe1", nrst, 132);
      chk("R3 pad drive cycles oe1", ndrv, 132);
      rd(2'd2, d); chk("R10 flag and oe kept", d, 8'hC0);

      // external low before any overflow
      wr(2'd2, 8'h40); ext_hold = 1'b1; idle(4);
      chk("R5 ext reset asserted", sys_rst_o, 1'b1);
      chk("R5 ext no pad drive", pad_drive_o, 1'b0);
      rd(2'd2, d); chk("R5 oe cleared by ext", d, 8'h00);
      ext_hold = 1'b0; idle(5);
      chk("R5 ext reset released", sys_rst_o, 1'b0);

      // coincidence, OE=1, pad held past window
      wr(2'd2, 8'h40); coincide();
      ndrv = 0;
      for (int n = 0; n < 526; n++) begin
         if (n == 0) chk("R6 watchdog wins drive", pad_drive_o, 1'b1);
         if (n == 300) begin rd(2'd2, d); chk("R6 flag during window", d, 8'hC0); end
         if (n == 519) chk("R6 no reset before window end", sys_rst_o, 1'b0);
         if (n == 520) chk("R6 ext reset at window end", sys_rst_o, 1'b1);
         ndrv += int'(pad_drive_o);
         @(negedge clk);
      end
      chk("R6 pulse length in coincidence", ndrv, 132);
      rd(2'd2, d); chk("R6 status cleared by late ext", d, 8'h00);
      ext_hold = 1'b0; idle(5);

      // coincidence, OE=1, pad released during window
      wr(2'd2, 8'h40); coincide();
      for (int n = 0; n < 526; n++) begin
         if (n == 200) ext_hold = 1'b0;
         if (n == 520) chk("R6 released pad no ext reset", sys_rst_o, 1'b0);
         @(negedge clk);
      end
      rd(2'd2, d); chk("R6 status kept after release", d, 8'hC0);

      // coincidence, OE=0, flag previously set
      wr(2'd2, 8'h80); coincide();
      chk("R7 ext wins reset", sys_rst_o, 1'b1);
      chk("R7 no pad drive", pad_drive_o, 1'b0);
      rd(2'd2, d); chk("R7 flag cleared", d, 8'h00);
      idle(10);
      chk("R7 still held by pad", sys_rst_o, 1'b1);
      ext_hold = 1'b0; idle(5);
      chk("R7 released", sys_rst_o, 1'b0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule